// File: doc/BRIEF.md
# Interleaved SAR conversion sequencer

This block times a bank of parallel successive-approximation converter slices that share one analog input. Each slice follows the same fixed frame of sixteen clocks. The frame holds a reference-zero sample slot, an auto-zero compare slot, a gain-calibration compare slot, an input sample slot, nine bit-decision slots, two hold slots and a data hand-off slot. The frames of neighbouring slices are offset by one clock. As a result, exactly one slice takes the input in every cycle, and the bank together delivers one conversion per clock.

One free-running phase counter drives all slices. Each slice adds its own fixed offset to that count and decodes its current slot. From the slot it drives its phase strobes, and it runs its own 9-bit successive-approximation register. That register is fed by the slice's comparator bit and presents a trial code to the slice's DAC. The output stage uses the one-hot sample vector and the per-slice hand-off strobes to collect results in order.

The reset input is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `interleaved_sar_seq`

## Requirements
- R1: While reset is active, every slice k sits at phase k and all SAR registers read zero, so `sample_now` equals 16'h0008. After `rst_n` rises, the phases stay frozen for two more rising edges and first advance on the third rising edge.
- R2: A slice at phase 0 drives `refz_stb`, at phase 1 `azero_stb`, at phase 2 `cal_stb`, at phase 3 `sample_now` and at phase 15. It drives `xfer_stb`. A slice asserts at most one of these strobes in any cycle, and none at phases 4 to 14.
- R3: The phase of slice k always equals (phase of slice 0 + k) mod 16, so exactly one bit of `sample_now` is set in every cycle.
- R4: Out of reset, every slice phase advances by one on each rising clock edge and wraps from 15 to 0.
- R5: At phases 4 to 12 a slice tests SAR bits 8 down to 0, one bit per phase with the MSB first. Its trial code is the bits already decided, plus a one in the bit under test, plus zeros below that bit. Slice k's trial code is `trial_code[9k+8:9k]`.
- R6: At the edge that ends a test phase, the tested bit is kept if `cmp_bit[k]` is 1 (input at or above the trial code) and cleared if it is 0.
- R7: The SAR value is held through phases 13, 14 and 15. At phase 15, `sar_result[9k+8:9k]` equals the code captured at that slice's last sample phase, including the extreme codes 0 and 511.
- R8: The edge that ends the sample phase clears the SAR register, so the trial code at phase 4 is 9'h100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sequencing on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| cmp_bit | input | 16 | Per-slice comparator decision: 1 when the input is at or above the trial code |
| refz_stb | output | 16 | Per-slice reference-zero sample strobe |
| azero_stb | output | 16 | Per-slice auto-zero compare strobe |
| cal_stb | output | 16 | Per-slice calibration compare strobe |
| sample_now | output | 16 | One-hot vector of the slice sampling the input this cycle |
| xfer_stb | output | 16 | Per-slice data hand-off strobe |
| trial_code | output | 144 | Per-slice 9-bit trial DAC code, slice k at bits 9k+8:9k |
| sar_result | output | 144 | Per-slice 9-bit SAR register, valid for hand-off at phase 15 |

## Verification
A corrupted phase count moves every strobe of the bank at once, so it appears on `sample_now` and the other strobe vectors in the very cycle after the bad edge. A wrong per-slice offset or slot decode shows as a misplaced strobe bit within one frame of sixteen cycles. A fault in the SAR datapath shows on `trial_code` in the next test phase of that slice, at most nine cycles later. It also surfaces as a wrong `sar_result` at the following hand-off slot. The bench keeps a behavioural phase and captured-code model per slice and compares every strobe, every trial code in the test window and every hand-off value on each clock.

// File: rtl/isq_pkg.sv
package isq_pkg;

  // Fixed slot positions inside a slice frame (0-based phase numbers).
  localparam int PH_REFZ      = 0;
  localparam int PH_AZERO     = 1;
  localparam int PH_CAL       = 2;
  localparam int PH_SAMPLE    = 3;
  localparam int PH_FIRST_BIT = 4;

  typedef enum logic [2:0] {
    SLOT_REFZ,
    SLOT_AZERO,
    SLOT_CAL,
    SLOT_SAMPLE,
    SLOT_CONV,
    SLOT_HOLD,
    SLOT_XFER
  } slot_e;

endpackage

// File: rtl/isq_rst_sync.sv
module isq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/isq_frame_timer.sv
module isq_frame_timer #(
  parameter int FRAME_LEN = 16,
  parameter int PH_W      = 4
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  output logic [PH_W-1:0] base_phase
);

  localparam logic [PH_W-1:0] LAST = PH_W'(FRAME_LEN - 1);

  logic [PH_W-1:0] cnt_q;
  logic [PH_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cnt_q <= '0;
    else             cnt_q <= cnt_d;
  end

  assign base_phase = cnt_q;

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q == LAST) |=> (cnt_q == '0));

  // R4
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/isq_slice.sv
module isq_slice
  import isq_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int SAR_W     = 9,
  parameter int PH_W      = 4,
  parameter int OFFSET    = 0
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic [PH_W-1:0]  base_phase,
  input  logic             cmp_bit,
  output logic             refz_stb,
  output logic             azero_stb,
  output logic             cal_stb,
  output logic             sample_stb,
  output logic             xfer_stb,
  output logic [SAR_W-1:0] trial,
  output logic [SAR_W-1:0] result
);

  localparam logic [PH_W:0] OFS      = (PH_W+1)'(OFFSET % FRAME_LEN);
  localparam logic [PH_W:0] FL       = (PH_W+1)'(FRAME_LEN);
  localparam int            LAST_BIT = PH_FIRST_BIT + SAR_W - 1;

  logic [PH_W:0]    sum;
  logic [PH_W-1:0]  phase;
  int               phase_i;
  slot_e            slot;
  logic [SAR_W-1:0] mask;
  logic [SAR_W-1:0] sar_q;
  logic [SAR_W-1:0] sar_d;
  logic             sar_en;

  // Local phase = shared count + slice offset, modulo frame length.
  always_comb begin
    sum = {1'b0, base_phase} + OFS;
    if (sum >= FL) phase = PH_W'(sum - FL);
    else           phase = PH_W'(sum);
  end

  assign phase_i = int'(phase);

  always_comb begin
    if      (phase_i == PH_REFZ)    slot = SLOT_REFZ;
    else if (phase_i == PH_AZERO)   slot = SLOT_AZERO;
    else if (phase_i == PH_CAL)     slot = SLOT_CAL;
    else if (phase_i == PH_SAMPLE)  slot = SLOT_SAMPLE;
    else if (phase_i <= LAST_BIT)   slot = SLOT_CONV;
    else if (phase_i == FRAME_LEN - 1) slot = SLOT_XFER;
    else                            slot = SLOT_HOLD;
  end

  assign refz_stb   = (slot == SLOT_REFZ);
  assign azero_stb  = (slot == SLOT_AZERO);
  assign cal_stb    = (slot == SLOT_CAL);
  assign sample_stb = (slot == SLOT_SAMPLE);
  assign xfer_stb   = (slot == SLOT_XFER);

  // Bit under test: MSB at the first conversion phase, LSB at the last.
  always_comb begin
    for (int i = 0; i < SAR_W; i++) begin
      mask[i] = (slot == SLOT_CONV) && (phase_i == LAST_BIT - i);
    end
  end

  assign sar_en = sample_stb | (slot == SLOT_CONV);

  always_comb begin
    if (sample_stb)   sar_d = '0;
    else if (cmp_bit) sar_d = sar_q | mask;
    else              sar_d = sar_q & ~mask;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sar_q <= '0;
    else if (sar_en)  sar_q <= sar_d;
  end

  assign trial  = sar_q | mask;
  assign result = sar_q;

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({refz_stb, azero_stb, cal_stb, sample_stb, xfer_stb}));

  // R6
  keep_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((slot == SLOT_CONV) && cmp_bit) |=> ((sar_q & $past(mask)) == $past(mask)));

  // R6
  drop_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((slot == SLOT_CONV) && !cmp_bit) |=> ((sar_q & $past(mask)) == '0));

  // R8
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sample_stb |=> (trial == {1'b1, {(SAR_W-1){1'b0}}}));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((slot == SLOT_HOLD) || xfer_stb) |=> $stable(result));

endmodule

// File: rtl/interleaved_sar_seq.sv
module interleaved_sar_seq #(
  parameter int NUM_SLICES = 16,
  parameter int FRAME_LEN  = 16,
  parameter int SAR_W      = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SLICES-1:0]       cmp_bit,
  output logic [NUM_SLICES-1:0]       refz_stb,
  output logic [NUM_SLICES-1:0]       azero_stb,
  output logic [NUM_SLICES-1:0]       cal_stb,
  output logic [NUM_SLICES-1:0]       sample_now,
  output logic [NUM_SLICES-1:0]       xfer_stb,
  output logic [NUM_SLICES*SAR_W-1:0] trial_code,
  output logic [NUM_SLICES*SAR_W-1:0] sar_result
);

  localparam int PH_W = $clog2(FRAME_LEN);

  logic            rst_sync_n;
  logic [PH_W-1:0] base_phase;

  isq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  isq_frame_timer #(
    .FRAME_LEN (FRAME_LEN),
    .PH_W      (PH_W)
  ) u_timer (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .base_phase (base_phase)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    isq_slice #(
      .FRAME_LEN (FRAME_LEN),
      .SAR_W     (SAR_W),
      .PH_W      (PH_W),
      .OFFSET    (k)
    ) u_slice (
      .clk        (clk),
      .rst_sync_n (rst_sync_n),
      .base_phase (base_phase),
      .cmp_bit    (cmp_bit[k]),
      .refz_stb   (refz_stb[k]),
      .azero_stb  (azero_stb[k]),
      .cal_stb    (cal_stb[k]),
      .sample_stb (sample_now[k]),
      .xfer_stb   (xfer_stb[k]),
      .trial      (trial_code[k*SAR_W +: SAR_W]),
      .result     (sar_result[k*SAR_W +: SAR_W])
    );
  end

  // R3
  one_sampler_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sample_now) == 1);

  // R3
  sampler_rotates_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> (sample_now == {$past(sample_now[NUM_SLICES-2:0]), $past(sample_now[NUM_SLICES-1])}
                           || sample_now == {$past(sample_now[0]), $past(sample_now[NUM_SLICES-1:1])}));

endmodule

// File: tb/tb_interleaved_sar_seq.sv
`timescale 1ns/1ps
module tb_interleaved_sar_seq;

  localparam int N = 16;
  localparam int W = 9;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   cmp_bit;
  logic [N-1:0]   refz_stb, azero_stb, cal_stb, sample_now, xfer_stb;
  logic [N*W-1:0] trial_code, sar_result;

  int ph [N];
  int held [N];
  int hold_cnt;
  int stim;
  int compared;
  int mismatched;
  bit done;

  interleaved_sar_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_bit    (cmp_bit),
    .refz_stb   (refz_stb),
    .azero_stb  (azero_stb),
    .cal_stb    (cal_stb),
    .sample_now (sample_now),
    .xfer_stb   (xfer_stb),
    .trial_code (trial_code),
    .sar_result (sar_result)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Comparator model: input code held since the slice's sample slot.
  always_comb begin
    for (int k = 0; k < N; k++) begin
      cmp_bit[k] = (held[k] >= int'(trial_code[k*W +: W]));
    end
  end

  // Behavioural phase model.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) ph[k] = k;
      hold_cnt = 2;
    end else if (hold_cnt > 0) begin
      hold_cnt = hold_cnt - 1;
    end else begin
      for (int k = 0; k < N; k++) ph[k] = (ph[k] + 1) % 16;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int k = 0; k < N; k++) begin
      int exp_s;
      int act_s;
      exp_s = ((ph[k] == 0) ? 16 : 0) | ((ph[k] == 1) ? 8 : 0) | ((ph[k] == 2) ? 4 : 0)
            | ((ph[k] == 3) ? 2 : 0) | ((ph[k] == 15) ? 1 : 0);
      act_s = {27'd0, refz_stb[k], azero_stb[k], cal_stb[k], sample_now[k], xfer_stb[k]};
      check(act_s == exp_s, "R2 R3 R4 strobes", act_s, exp_s);
      if (ph[k] >= 4 && ph[k] <= 12) begin
        int b;
        int e;
        b = ph[k] - 4;
        e = ((held[k] >> (9 - b)) << (9 - b)) | (1 << (8 - b));
        check(int'(trial_code[k*W +: W]) == e, "R5 R6 trial", int'(trial_code[k*W +: W]), e);
        if (ph[k] == 4)
          check(int'(trial_code[k*W +: W]) == 256, "R8 cleared", int'(trial_code[k*W +: W]), 256);
      end
      if (ph[k] == 15)
        check(int'(sar_result[k*W +: W]) == held[k], "R7 result", int'(sar_result[k*W +: W]), held[k]);
    end
  endtask

  function automatic int pattern(input int cyc);
    int seg;
    seg = (cyc / 70) % 5;
    case (seg)
      0: return 0;
      1: return 511;
      2: return (cyc * 37) % 512;
      3: return (cyc % 2 == 0) ? 9'h155 : 9'h0AA;
      default: return int'($urandom % 512);
    endcase
  endfunction

  initial begin
    compared = 0;
    mismatched = 0;
    done = 0;
    rst_n = 1'b0;
    stim = 0;
    hold_cnt = 2;
    for (int k = 0; k < N; k++) begin
      ph[k] = k;
      held[k] = 0;
    end
    for (int cyc = 0; cyc < 420; cyc++) begin
      @(negedge clk);
      if (cyc == 3) begin
        // R1 reset state
        check(sample_now == 16'h0008, "R1 sample_now in reset", int'(sample_now), 8);
        check(sar_result == '0, "R1 results cleared", int'(sar_result[W-1:0]), 0);
      end
      if (cyc >= 1) compare_all();
      rst_n = !(cyc < 4 || (cyc >= 230 && cyc < 233));
      stim = pattern(cyc);
      for (int k = 0; k < N; k++) begin
        if (!rst_n) held[k] = 0;
        else if (ph[k] == 3) held[k] = stim;
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule